// File: doc/BRIEF.md
# Two-Wire Register Target with Strapped Address

This block is a target on a two-wire I2C/SMBus-style bus. It holds three 8-bit read/write registers: a mute register, a shutdown register and a control register. A fast system clock oversamples the bus clock and data lines, which are passed through synchronizers. The block finds START and STOP conditions, shifts bytes in and out MSB first, and checks the 7-bit address. It acknowledges on the ninth clock and pulls the data line low through an open-drain enable. The host reaches the contents over the bus. The register values also appear on plain output pins, where the rest of the chip reads them.

The upper five address bits are fixed at `10010`. The lowest two come from a single strap pin, which the board ties to ground, to supply, to the data line or to the clock line. The block works out which of the four connections is present. It does this by noting whether the synchronized strap level has ever differed from the data line and from the clock line. A host write sends a register pointer first and a value second. A host read returns the register at the current pointer. The bus lines and the registers carry no back-pressure, so there is no valid/ready interface. The host paces every transfer with the clock, and the block never holds the clock low.

Top module: `i2c_strap_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `10010` followed by the two strap-derived bits. It acknowledges by pulling the data line low during the ninth clock. Bit 0 of the address byte selects the direction: 0 is write and 1 is read.
- R2: A START is the data line falling while the clock is high, and a STOP is the data line rising while the clock is high. A START, including a repeated START in the middle of a transfer, always returns the target to address reception.
- R3: Bytes are transferred MSB first in eight clocks. The acknowledge follows on a ninth clock.
- R4: The strap decodes as follows. Tied to ground gives `00` and tied to supply gives `01`. Following the data line gives `10` and following the clock line gives `11`.
- R5: When the address does not match, the target does not acknowledge. It leaves the data line released and changes no register until the next START.
- R6: In a write, the first data byte is the register pointer: 0x00 is mute, 0x01 is shutdown and 0x02 is control. The next byte is stored into that register. Both bytes are acknowledged, and any further bytes overwrite the same register.
- R7: A pointer of 0x03 or above is not acknowledged, and no register is written.
- R8: Writing the shutdown register with any of bits 2 to 7 set clears all three registers to 0x00. A value with only bits 0 and 1 set is stored as written, and bit 0 is the shutdown flag on `shdn_o[0]`.
- R9: In a read, the target drives the register selected by the last pointer, MSB first, after its address acknowledge. If the host acknowledges, the same register is sent again. A host NACK ends the read.
- R10: After reset, all three registers read 0x00 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 1 | Address strap pin, tied to ground, supply, data line or clock line |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| mute_o | output | 8 | Mute register contents |
| shdn_o | output | 8 | Shutdown register contents; bit 0 is the shutdown flag |
| ctrl_o | output | 8 | Control register contents |

## Verification
The bench sweeps all four strap connections, and each one gets a fresh reset. Under each connection it writes a distinct value to every register and reads it back with a repeated START. It also sends the three other address variants, which must be refused and must leave the registers unchanged. Together these show that the address match really depends on the decoded strap bits and not on a fixed address. Pointer 0x03 and each single shutdown bit from 2 to 7 are then applied in turn. This separates the out-of-range NACK from the reset-all path, and separates the reset-all path from an ordinary store of bits 0 and 1. A two-byte read with a host acknowledge between the bytes confirms that the register is sent again.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 3;
  localparam int PTR_W    = $clog2(NUM_REGS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_READ
  } bus_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  output logic scl_s,
  output logic sda_s,
  output logic strap_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 3;

  logic [LINES-1:0] chain [SYNC_STAGES];
  logic             scl_d, sda_d;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '1;
        else if (g == 0) chain[g] <= {strap_i, sda_i, scl_i};
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign scl_s   = chain[SYNC_STAGES-1][0];
  assign sda_s   = chain[SYNC_STAGES-1][1];
  assign strap_s = chain[SYNC_STAGES-1][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt)); // R2
endmodule

// File: rtl/i2cs_strap_dec.sv
module i2cs_strap_dec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       strap_s,
  output logic [1:0] addr_lo
);
  logic diff_sda, diff_scl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_sda <= 1'b0;
      diff_scl <= 1'b0;
    end else begin
      if (strap_s != sda_s) diff_sda <= 1'b1;
      if (strap_s != scl_s) diff_scl <= 1'b1;
    end
  end

  always_comb begin
    if (!diff_sda)      addr_lo = 2'b10;
    else if (!diff_scl) addr_lo = 2'b11;
    else                addr_lo = {1'b0, strap_s};
  end

  AST_STRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(diff_sda) |-> diff_sda); // R4
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b10010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [1:0]        addr_lo,
  input  logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_oe
);
  bus_state_e        state;
  logic [3:0]        cnt;
  logic              in_ack, rw, mnack;
  logic [DATA_W-1:0] shreg, tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; in_ack <= 1'b0; rw <= 1'b0; mnack <= 1'b0;
      shreg <= '0; tx <= '0; ptr <= '0; wr_en <= 1'b0; wr_data <= '0; sda_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state <= ST_ADDR; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state <= ST_IDLE; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (!in_ack && cnt < 4'd8) begin
            cnt <= cnt + 4'd1;
            if (state != ST_READ) shreg <= {shreg[DATA_W-2:0], sda_s};
          end else if (in_ack && state == ST_READ) begin
            mnack <= sda_s;
          end
        end else if (scl_fall) begin
          if (!in_ack && cnt == 4'd8) begin
            in_ack <= 1'b1;
            unique case (state)
              ST_ADDR: begin
                if (shreg[7:1] == {ADDR_HI, addr_lo}) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  state <= ST_IDLE; in_ack <= 1'b0; cnt <= '0;
                end
              end
              ST_PTR: begin
                if (shreg < DATA_W'(NUM_REGS)) begin
                  sda_oe <= 1'b1;
                  ptr    <= shreg[PTR_W-1:0];
                end else begin
                  state <= ST_IDLE; in_ack <= 1'b0; cnt <= '0;
                end
              end
              ST_DATA: begin
                sda_oe  <= 1'b1;
                wr_en   <= 1'b1;
                wr_data <= shreg;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= '0;
            sda_oe <= 1'b0;
            unique case (state)
              ST_ADDR: begin
                if (rw) begin
                  state  <= ST_READ;
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[DATA_W-1];
                end else begin
                  state <= ST_PTR;
                end
              end
              ST_PTR:  state <= ST_DATA;
              ST_DATA: state <= ST_DATA;
              default: begin
                if (mnack) state <= ST_IDLE;
                else begin
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[DATA_W-1];
                end
              end
            endcase
          end else if (state == ST_READ && cnt != 4'd0) begin
            sda_oe <= ~tx[3'd7 - cnt[2:0]];
          end
        end
      end
    end
  end

  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt == 4'd0 && state == ST_ADDR)); // R2
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R5
  AST_WRITE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == ST_DATA)); // R6
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2cs_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b10010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_oe,
  output logic [DATA_W-1:0] mute_o,
  output logic [DATA_W-1:0] shdn_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int SHDN_IDX = 1;

  logic scl_s, sda_s, strap_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [1:0]        addr_lo;
  logic [PTR_W-1:0]  ptr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              clear_all;

  i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .strap_i(strap_i),
    .scl_s(scl_s), .sda_s(sda_s), .strap_s(strap_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt));

  i2cs_strap_dec strap_i0 (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .strap_s(strap_s), .addr_lo(addr_lo));

  i2cs_engine #(.ADDR_HI(ADDR_HI)) eng_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_lo(addr_lo), .rd_data(regs[ptr]), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_oe(sda_oe));

  assign clear_all = wr_en && (ptr == PTR_W'(SHDN_IDX)) && (|wr_data[7:2]);

  genvar r;
  generate
    for (r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  regs[r] <= '0;
        else if (clear_all)                          regs[r] <= '0;
        else if (wr_en && ptr == PTR_W'(r))          regs[r] <= wr_data;
      end
    end
  endgenerate

  assign mute_o = regs[0];
  assign shdn_o = regs[1];
  assign ctrl_o = regs[2];

  AST_SHDN_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == PTR_W'(SHDN_IDX) && wr_data[7:2] != 6'd0)
      |=> (mute_o == 8'h00 && shdn_o == 8'h00 && ctrl_o == 8'h00)); // R8
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({mute_o, shdn_o, ctrl_o})); // R5
endmodule

// File: tb/i2c_strap_target_tb_top.sv
`timescale 1ns/1ps
module i2c_strap_target_tb_top;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [7:0] mute_o, shdn_o, ctrl_o;
  logic sda_line, strap;
  int   mode = 0;
  int   n_chk = 0, n_fail = 0;
  logic [7:0] model [3];

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;
  assign strap = (mode == 2) ? sda_line : (mode == 3) ? m_scl : mode[0];

  i2c_strap_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
    .sda_oe(sda_oe), .mute_o(mute_o), .shdn_o(shdn_o), .ctrl_o(ctrl_o));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", req, mode, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
    end
    m_sda = nack; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  function automatic logic [7:0] own_addr(input int lo, input logic rd);
    return {5'b10010, lo[1:0], rd};
  endfunction

  task automatic wr_reg(input int lo, input logic [7:0] p, input logic [7:0] v,
                        output logic a0, output logic a1, output logic a2);
    a1 = 1'b0; a2 = 1'b0;
    bus_start();
    send_byte(own_addr(lo, 1'b0), a0);
    if (a0) send_byte(p, a1);
    if (a0 && a1) send_byte(v, a2);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] p, input int nbytes,
                        output logic [7:0] d0, output logic [7:0] d1, output logic ack);
    logic a;
    d1 = 8'h00;
    bus_start();
    send_byte(own_addr(mode, 1'b0), a);
    send_byte(p, a);
    bus_start();
    send_byte(own_addr(mode, 1'b1), ack);
    recv_byte(nbytes == 1, d0);
    if (nbytes > 1) recv_byte(1'b1, d1);
    bus_stop();
  endtask

  task automatic apply_write(input logic [7:0] p, input logic [7:0] v);
    if (p == 8'd1 && v[7:2] != 6'd0) begin
      model[0] = 8'h00; model[1] = 8'h00; model[2] = 8'h00;
    end else if (p < 8'd3) begin
      model[p[1:0]] = v;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    logic a0, a1, a2, ack;
    logic [7:0] d0, d1, v;
    for (int m = 0; m < 4; m++) begin
      mode = m;
      rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
      tick(4); rst_n = 1'b1; tick(4);
      model[0] = 8'h00; model[1] = 8'h00; model[2] = 8'h00;
      // R10 reset state
      chk("R10 mute", mute_o, 8'h00);
      chk("R10 shdn", shdn_o, 8'h00);
      chk("R10 ctrl", ctrl_o, 8'h00);
      chk("R10 sda released", {7'd0, sda_oe}, 8'h00);

      // R1 R3 R4 R6: write each register under the strapped address
      for (int p = 0; p < 3; p++) begin
        v = (p == 1) ? 8'(m & 3) : 8'((m << 6) | (p << 3) | 5);
        wr_reg(m, 8'(p), v, a0, a1, a2);
        apply_write(8'(p), v);
        chk("R1 R4 address ack", {7'd0, a0}, 8'h01);
        chk("R6 pointer ack", {7'd0, a1}, 8'h01);
        chk("R6 data ack", {7'd0, a2}, 8'h01);
      end
      chk("R6 mute pin", mute_o, model[0]);
      chk("R8 shdn stored bits0-1", shdn_o, model[1]);
      chk("R6 ctrl pin", ctrl_o, model[2]);

      // R9 R2: read back each register through a repeated START
      for (int p = 0; p < 3; p++) begin
        rd_reg(8'(p), 1, d0, d1, ack);
        chk("R9 read addr ack", {7'd0, ack}, 8'h01);
        chk("R9 R3 read data", d0, model[p]);
      end

      // R5: other strap values are refused and leave registers unchanged
      for (int lo = 0; lo < 4; lo++) begin
        if (lo != m) begin
          wr_reg(lo, 8'd2, 8'hFF, a0, a1, a2);
          chk("R5 R4 foreign address nack", {7'd0, a0}, 8'h00);
          chk("R5 ctrl unchanged", ctrl_o, model[2]);
          chk("R5 released", {7'd0, sda_oe}, 8'h00);
        end
      end

      // R7: out-of-range pointer
      wr_reg(m, 8'd3, 8'h77, a0, a1, a2);
      chk("R7 bad pointer nack", {7'd0, a1}, 8'h00);
      chk("R7 mute unchanged", mute_o, model[0]);
      chk("R7 ctrl unchanged", ctrl_o, model[2]);

      // R8: each of bits 2..7 of shutdown clears everything
      for (int k = 2; k < 8; k++) begin
        wr_reg(m, 8'd0, 8'h18, a0, a1, a2); apply_write(8'd0, 8'h18);
        wr_reg(m, 8'd2, 8'hA5, a0, a1, a2); apply_write(8'd2, 8'hA5);
        chk("R6 ctrl before clear", ctrl_o, 8'hA5);
        wr_reg(m, 8'd1, 8'(1 << k), a0, a1, a2); apply_write(8'd1, 8'(1 << k));
        chk("R8 data ack", {7'd0, a2}, 8'h01);
        chk("R8 mute cleared", mute_o, 8'h00);
        chk("R8 shdn cleared", shdn_o, 8'h00);
        chk("R8 ctrl cleared", ctrl_o, 8'h00);
      end

      // R8: shutdown flag alone
      wr_reg(m, 8'd1, 8'h01, a0, a1, a2); apply_write(8'd1, 8'h01);
      chk("R8 shutdown flag", shdn_o, 8'h01);

      // R9: host ack repeats the register, then NACK ends
      wr_reg(m, 8'd2, 8'h3C + 8'(m), a0, a1, a2); apply_write(8'd2, 8'h3C + 8'(m));
      rd_reg(8'd2, 2, d0, d1, ack);
      chk("R9 first byte", d0, model[2]);
      chk("R9 repeated byte", d1, model[2]);
      chk("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule